// File: doc/BRIEF.md
# Staircase Soft-Start Reference Sequencer

This block produces the digital setpoint code that a reference DAC turns into the error-amplifier target of a voltage-mode buck controller. After enable, the code climbs from zero to full scale in equal steps. It advances only on a one-cycle strobe that marks each switching period. Because of this, the ramp time follows the switching frequency. With 64 steps of 32 periods each, a ramp lasts 2048 periods, which is about 8 ms at 250 kHz. Each step is roughly 9.5 mV of a 0.6 V target.

When the output is in regulation, an overcurrent controller can ask for a restart. The code then drops to zero and stays there for a full 2048-period interval, after which a new ramp begins. A restart that arrives during the ramp is ignored, because current limiting during start-up is done pulse by pulse elsewhere. The soft-start-active flag tells that controller which of its two policies applies. The ramp-done flag marks regulation.

Top module: `softstart_stair`

## Requirements
- R1: During reset, and whenever `en` is low, `ref_code` is 0 and both `ss_active` and `ramp_done` are low.
- R2: On the first clock with `en` high after it was low, the block enters the ramp: `ss_active` goes high with `ref_code` = 0. A strobe in that same clock is not counted.
- R3: During the ramp, after n counted strobes, `ref_code` equals n/32 rounded down (a 6-bit binary code, steps 0 to 63).
- R4: Clocks without `cyc_stb` high never change `ref_code` or the flags. Only `en` and `restart` can act without a strobe.
- R5: The 2048th strobe of a ramp clears `ss_active`, sets `ramp_done` and leaves `ref_code` at 63. Further strobes keep it at 63.
- R6: A `restart` while `ramp_done` is high sets `ref_code` to 0 and clears both flags for 2048 strobes. The 2048th strobe starts a new ramp (`ss_active` high, code 0).
- R7: A `restart` during the zero-hold interval resets the hold count, so 2048 further strobes are needed before the ramp.
- R8: A `restart` during the ramp has no effect on `ref_code` or the flags.
- R9: Dropping `en` during a ramp or a hold clears everything in the next clock. Raising it again starts a ramp from step 0.
- R10: `ss_active` stays high for every clock of the ramp, from step 0 through step 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable; low forces the off state |
| cyc_stb | input | 1 | One-clock strobe per switching period |
| restart | input | 1 | Restart request from the overcurrent controller |
| ref_code | output | 6 | Reference step code for the DAC |
| ss_active | output | 1 | High while the ramp is in progress |
| ramp_done | output | 1 | High once the ramp has completed |

## Verification
The embedded assertions check on every clock the following properties:
- the code holds steady when no strobe arrives;
- the code climbs at most one step per strobe during the ramp;
- disable forces the off state;
- done is only entered from full scale;
- a restart in regulation leads to the zero-hold state.

The absolute step values, the 2048-strobe lengths of the ramp and of the hold, the restarted hold count and the re-enable ramp can only be shown by the bench. It does this with full sweeps that count strobes and compare each code with the strobe count divided by 32.

// File: rtl/softstart_stair.sv
module softstart_stair #(
  parameter int STEPS = 64,
  parameter int CYC_PER_STEP = 32,
  localparam int CODE_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cyc_stb,
  input  logic              restart,
  output logic [CODE_W-1:0] ref_code,
  output logic              ss_active,
  output logic              ramp_done
);
  localparam int SUB_W = $clog2(CYC_PER_STEP);
  localparam int CNT_W = CODE_W + SUB_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS * CYC_PER_STEP - 1);

  typedef enum logic [1:0] {S_OFF, S_RAMP, S_DONE, S_HOLD} st_t;

  st_t st;
  logic [CNT_W-1:0] cnt;
  logic at_last;

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      case (st)
        S_OFF: begin
          st  <= S_RAMP;
          cnt <= '0;
        end
        S_RAMP: if (cyc_stb) begin
          if (at_last) begin
            st  <= S_DONE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_DONE: if (restart) begin
          st  <= S_HOLD;
          cnt <= '0;
        end
        S_HOLD: begin
          if (restart) cnt <= '0;
          else if (cyc_stb) begin
            if (at_last) begin
              st  <= S_RAMP;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st  <= S_OFF;
          cnt <= '0;
        end
      endcase
    end
  end

  assign ref_code  = (st == S_DONE) ? '1 :
                     (st == S_RAMP) ? cnt[CNT_W-1:SUB_W] : '0;
  assign ss_active = (st == S_RAMP);
  assign ramp_done = (st == S_DONE);

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cyc_stb && !restart) |=> $stable(ref_code));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ss_active && cyc_stb) |=>
      (ref_code == $past(ref_code) || ref_code == $past(ref_code) + CODE_W'(1)));

  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ref_code == '0 && !ss_active && !ramp_done));

  // R5
  done_from_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_done) |-> ($past(ref_code) == '1));

  // R6
  restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ramp_done && restart) |=> (ref_code == '0 && !ss_active && !ramp_done));
endmodule

// File: tb/softstart_stair_bench.sv
module softstart_stair_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0, cyc_stb = 1'b0, restart = 1'b0;
  logic [5:0] ref_code;
  logic ss_active, ramp_done;
  int vectors = 0, fails = 0;

  always #4 clk = ~clk;

  softstart_stair u_softstart_stair (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_stb(cyc_stb), .restart(restart),
    .ref_code(ref_code), .ss_active(ss_active), .ramp_done(ramp_done)
  );

  task automatic chk(input string req, input int c, input bit a, input bit d);
    vectors++;
    if (ref_code !== 6'(c) || ss_active !== a || ramp_done !== d) begin
      fails++;
      $display("FAIL %s: got code=%0d act=%b done=%b, expected code=%0d act=%b done=%b",
               req, ref_code, ss_active, ramp_done, c, a, d);
    end
  endtask

  task automatic pulse();
    @(negedge clk); cyc_stb = 1'b1;
    @(negedge clk); cyc_stb = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic full_ramp(input string req, input bit probe);
    for (int n = 1; n <= 2048; n++) begin
      pulse();
      if (n < 2048) chk(req, n / 32, 1'b1, 1'b0);
      else chk("R5 ramp end", 63, 1'b0, 1'b1);
      if (probe && n % 7 == 0 && n < 2048) begin
        idle(3);
        chk("R4 no strobe", n / 32, 1'b1, 1'b0);
      end
      if (probe && n == 1000) begin
        kick();
        chk("R8 restart in ramp", n / 32, 1'b1, 1'b0);
      end
    end
  endtask

  initial begin
    idle(3);
    chk("R1 reset", 0, 0, 0);
    rst_n = 1'b1;
    pulse(); pulse();
    chk("R1 disabled", 0, 0, 0);

    en = 1'b1; cyc_stb = 1'b1;
    @(negedge clk); cyc_stb = 1'b0;
    chk("R2 enable", 0, 1, 0);

    full_ramp("R3 R10 ramp", 1'b1);
    for (int k = 0; k < 5; k++) begin
      pulse();
      chk("R5 saturate", 63, 0, 1);
    end

    kick();
    chk("R6 restart", 0, 0, 0);
    for (int n = 1; n <= 1000; n++) pulse();
    chk("R6 hold", 0, 0, 0);
    kick();
    for (int n = 1; n <= 2047; n++) begin
      pulse();
      chk("R7 hold recount", 0, 0, 0);
    end
    pulse();
    chk("R6 new ramp", 0, 1, 0);
    for (int n = 1; n <= 40; n++) pulse();
    chk("R3 after hold", 1, 1, 0);

    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R9 disable in ramp", 0, 0, 0);
    pulse(); kick();
    chk("R9 while off", 0, 0, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R9 re-enable", 0, 1, 0);
    for (int n = 1; n <= 32; n++) begin
      pulse();
      chk("R9 ramp from zero", n / 32, 1, 0);
    end
    for (int n = 33; n <= 2048; n++) pulse();
    chk("R5 second ramp", 63, 0, 1);

    kick();
    for (int n = 1; n <= 10; n++) pulse();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R9 disable in hold", 0, 0, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R9 re-enable after hold", 0, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule